// File: doc/BRIEF.md
# Frame-Linear Display Timing Generator

This block produces the sync, data-enable and pixel stream of a raster display from timing values that arrive on static configuration ports. Two counters drive it: a line counter that wraps every line period, and one linear position counter that spans the whole frame and wraps at the frame length. Both counters are zero at the leading edge of the sync pulses. The vertical sync length and the vertical visible window are therefore written as pixel-clock offsets into the frame (a line count multiplied by the line length), not as line numbers.

While a position falls inside both the horizontal and the vertical window, the block asks an upstream pixel source for a pixel. The sampled pixel goes out one cycle later, aligned with data-enable. Outside the window a border color goes out. If the source has no pixel ready, the slot gets the underflow color when recovery is on, or black when it is off. Scanning never stalls. All configuration is captured into shadow registers when scanning starts and at every frame wrap, so a change made mid-frame cannot tear the timing. A cleared enable also takes effect only at the frame wrap, which is marked by a one-cycle event output.

Top module: `frame_scan_timer`

## Requirements
- R1: After reset, hsync, vsync, de, pix_req, scan_active and frame_evt are 0 and pix_out is all zeros.
- R2: With cfg_enable low the block stays idle (scan_active 0). When cfg_enable is sampled high while idle, scan_active is 1 from the next cycle, and both counters start at position 0.
- R3: The outputs shown in cycle k+1 belong to frame position k. Within each line, hsync is active for line positions 0 to cfg_hsync_width−1, and a line is cfg_line_len positions long.
- R4: vsync is active for frame positions below cfg_vsync_span. The frame is cfg_frame_len positions long.
- R5: de is 1 exactly when the line position lies in [cfg_hact_first, cfg_hact_last] and the frame position lies in [cfg_vact_first+cfg_vskew, cfg_vact_last+cfg_vskew], both bounds inclusive.
- R6: pix_req is high in the cycle whose frame position will be shown with de high in the next cycle. A pixel that src_pixel presents with src_valid high in that cycle appears on pix_out in the next cycle.
- R7: Outside the window, pix_out carries cfg_border. The same holds while the block is idle.
- R8: A requested slot with src_valid low outputs cfg_uf_color when cfg_uf_recover is 1, and 0 when it is 0. Scanning continues in both cases.
- R9: cfg_hsync_low = 1 makes hsync active-low, and cfg_vsync_low = 1 makes vsync active-low. When idle, each sync sits at its inactive level.
- R10: Clearing cfg_enable stops scanning only at the frame wrap. frame_evt pulses for one cycle, in the cycle that shows the last position of each frame, and scan_active is already 0 in that cycle when the enable was clear.
- R11: Configuration changes made during a frame do not affect that frame. They are applied from the next frame wrap on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Scan enable, acted on while idle or at a frame wrap |
| cfg_line_len | input | H_W | Line period in pixel clocks |
| cfg_hsync_width | input | H_W | Horizontal sync pulse width |
| cfg_hact_first | input | H_W | First visible line position |
| cfg_hact_last | input | H_W | Last visible line position (inclusive) |
| cfg_frame_len | input | F_W | Frame period in pixel clocks |
| cfg_vsync_span | input | F_W | Vertical sync length in pixel clocks |
| cfg_vact_first | input | F_W | First visible frame position before skew |
| cfg_vact_last | input | F_W | Last visible frame position before skew (inclusive) |
| cfg_vskew | input | F_W | Offset added to both vertical window bounds |
| cfg_hsync_low | input | 1 | Horizontal sync active-low |
| cfg_vsync_low | input | 1 | Vertical sync active-low |
| cfg_border | input | C_W | Color outside the window |
| cfg_uf_recover | input | 1 | Fill starved slots with the underflow color |
| cfg_uf_color | input | C_W | Underflow fill color |
| src_valid | input | 1 | Source has a pixel for the requested slot |
| src_pixel | input | C_W | Pixel from the source |
| pix_req | output | 1 | Pixel request to the source |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_out | output | C_W | Output pixel |
| scan_active | output | 1 | Scanning is running |
| frame_evt | output | 1 | One-cycle frame wrap pulse |

## Verification
The assertions assume a sane geometry: a nonzero line length, and a frame length that is a nonzero multiple of the line length and fits the counter. Under that assumption both counters stay below their shadowed limits and the line counter returns to zero at every line end. The bench builds every configuration from mode-style line and column numbers, using the offset formulas of the requirements, so each frame it programs is a whole number of lines with windows and sync spans inside the frame. Mid-frame changes touch only sync width, polarity and border, which leaves the geometry assumptions valid when they are taken up at the wrap.

// File: rtl/fst_pkg.sv
package fst_pkg;
  typedef enum logic [1:0] {
    FILL_SOURCE = 2'd0,
    FILL_UFLOW  = 2'd1,
    FILL_BLACK  = 2'd2,
    FILL_BORDER = 2'd3
  } fill_sel_e;
endpackage

// File: rtl/fst_shadow.sv
module fst_shadow #(
  parameter int H_W = 12,
  parameter int F_W = 24,
  parameter int C_W = 24
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           frame_last,
  input  logic           cfg_enable,
  input  logic [H_W-1:0] cfg_line_len,
  input  logic [H_W-1:0] cfg_hsync_width,
  input  logic [H_W-1:0] cfg_hact_first,
  input  logic [H_W-1:0] cfg_hact_last,
  input  logic [F_W-1:0] cfg_frame_len,
  input  logic [F_W-1:0] cfg_vsync_span,
  input  logic [F_W-1:0] cfg_vact_first,
  input  logic [F_W-1:0] cfg_vact_last,
  input  logic [F_W-1:0] cfg_vskew,
  input  logic           cfg_hsync_low,
  input  logic           cfg_vsync_low,
  input  logic [C_W-1:0] cfg_border,
  input  logic           cfg_uf_recover,
  input  logic [C_W-1:0] cfg_uf_color,
  output logic           running,
  output logic           evt,
  output logic [H_W-1:0] sh_line_len,
  output logic [H_W-1:0] sh_hsync_width,
  output logic [H_W-1:0] sh_hact_first,
  output logic [H_W-1:0] sh_hact_last,
  output logic [F_W-1:0] sh_frame_len,
  output logic [F_W-1:0] sh_vsync_span,
  output logic [F_W-1:0] sh_vact_first,
  output logic [F_W-1:0] sh_vact_last,
  output logic           sh_hsync_low,
  output logic           sh_vsync_low,
  output logic [C_W-1:0] sh_border,
  output logic           sh_uf_recover,
  output logic [C_W-1:0] sh_uf_color
);
  logic load;

  // Capture the configuration on start-up and at each frame wrap
  assign load = (!running && cfg_enable) || frame_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      running        <= 1'b0;
      evt            <= 1'b0;
      sh_line_len    <= '0;
      sh_hsync_width <= '0;
      sh_hact_first  <= '0;
      sh_hact_last   <= '0;
      sh_frame_len   <= '0;
      sh_vsync_span  <= '0;
      sh_vact_first  <= '0;
      sh_vact_last   <= '0;
      sh_hsync_low   <= 1'b0;
      sh_vsync_low   <= 1'b0;
      sh_border      <= '0;
      sh_uf_recover  <= 1'b0;
      sh_uf_color    <= '0;
    end else begin
      evt <= frame_last;
      if (!running || frame_last) running <= cfg_enable;
      if (load) begin
        sh_line_len    <= cfg_line_len;
        sh_hsync_width <= cfg_hsync_width;
        sh_hact_first  <= cfg_hact_first;
        sh_hact_last   <= cfg_hact_last;
        sh_frame_len   <= cfg_frame_len;
        sh_vsync_span  <= cfg_vsync_span;
        // the skew is folded into the vertical bounds once per frame
        sh_vact_first  <= cfg_vact_first + cfg_vskew;
        sh_vact_last   <= cfg_vact_last + cfg_vskew;
        sh_hsync_low   <= cfg_hsync_low;
        sh_vsync_low   <= cfg_vsync_low;
        sh_border      <= cfg_border;
        sh_uf_recover  <= cfg_uf_recover;
        sh_uf_color    <= cfg_uf_color;
      end
    end
  end

  // R10: a running scan only stops at the frame wrap
  p_stop_at_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (running && !frame_last) |=> running);

endmodule

// File: rtl/fst_counters.sv
module fst_counters #(
  parameter int H_W = 12,
  parameter int F_W = 24
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           running,
  input  logic [H_W-1:0] line_len,
  input  logic [F_W-1:0] frame_len,
  output logic [H_W-1:0] hcnt,
  output logic [F_W-1:0] fcnt,
  output logic           frame_last
);
  localparam logic [H_W-1:0] H_STEP = H_W'(1);
  localparam logic [F_W-1:0] F_STEP = F_W'(1);

  logic line_last;

  assign line_last  = (hcnt == line_len - H_STEP);
  assign frame_last = running && (fcnt == frame_len - F_STEP);

  always_ff @(posedge clk) begin
    if (rst || !running) begin
      hcnt <= '0;
      fcnt <= '0;
    end else begin
      hcnt <= (line_last || frame_last) ? '0 : hcnt + H_STEP;
      fcnt <= frame_last ? '0 : fcnt + F_STEP;
    end
  end

  // R3: the line counter stays inside the line period
  p_line_bound_r3: assert property (@(posedge clk) disable iff (rst)
    running |-> (hcnt < line_len));

  // R3: the line counter returns to zero after the last line position
  p_line_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (running && line_last) |=> (hcnt == '0));

  // R4: the frame counter stays inside the frame period
  p_frame_bound_r4: assert property (@(posedge clk) disable iff (rst)
    running |-> (fcnt < frame_len));

endmodule

// File: rtl/fst_output.sv
module fst_output
  import fst_pkg::*;
#(
  parameter int H_W = 12,
  parameter int F_W = 24,
  parameter int C_W = 24
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           running,
  input  logic [H_W-1:0] hcnt,
  input  logic [F_W-1:0] fcnt,
  input  logic [H_W-1:0] hsync_width,
  input  logic [H_W-1:0] hact_first,
  input  logic [H_W-1:0] hact_last,
  input  logic [F_W-1:0] vsync_span,
  input  logic [F_W-1:0] vact_first,
  input  logic [F_W-1:0] vact_last,
  input  logic           hsync_low,
  input  logic           vsync_low,
  input  logic [C_W-1:0] border,
  input  logic           uf_recover,
  input  logic [C_W-1:0] uf_color,
  input  logic           src_valid,
  input  logic [C_W-1:0] src_pixel,
  output logic           pix_req,
  output logic           hsync,
  output logic           vsync,
  output logic           de,
  output logic [C_W-1:0] pix_out
);
  logic      h_in, v_in, hs_on, vs_on, win;
  fill_sel_e sel;
  logic [C_W-1:0] pix_next;

  assign h_in  = (hcnt >= hact_first) && (hcnt <= hact_last);
  assign v_in  = (fcnt >= vact_first) && (fcnt <= vact_last);
  assign hs_on = running && (hcnt < hsync_width);
  assign vs_on = running && (fcnt < vsync_span);
  assign win   = running && h_in && v_in;

  // The request goes out one cycle ahead of the registered data enable
  assign pix_req = win;

  always_comb begin
    if (!win)           sel = FILL_BORDER;
    else if (src_valid) sel = FILL_SOURCE;
    else if (uf_recover) sel = FILL_UFLOW;
    else                sel = FILL_BLACK;
  end

  always_comb begin
    unique case (sel)
      FILL_SOURCE: pix_next = src_pixel;
      FILL_UFLOW:  pix_next = uf_color;
      FILL_BLACK:  pix_next = '0;
      default:     pix_next = border;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync   <= 1'b0;
      vsync   <= 1'b0;
      de      <= 1'b0;
      pix_out <= '0;
    end else begin
      hsync   <= hs_on ^ hsync_low;
      vsync   <= vs_on ^ vsync_low;
      de      <= win;
      pix_out <= pix_next;
    end
  end

  // R8: a starved slot under recovery carries the underflow color
  p_uf_fill_r8: assert property (@(posedge clk) disable iff (rst)
    (pix_req && !src_valid && uf_recover) |=> (pix_out == $past(uf_color)));

  // R6: an accepted pixel reaches the output with data enable
  p_src_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (pix_req && src_valid) |=> (de && pix_out == $past(src_pixel)));

endmodule

// File: rtl/frame_scan_timer.sv
module frame_scan_timer #(
  parameter int H_W = 12,
  parameter int F_W = 24,
  parameter int C_W = 24
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_enable,
  input  logic [H_W-1:0] cfg_line_len,
  input  logic [H_W-1:0] cfg_hsync_width,
  input  logic [H_W-1:0] cfg_hact_first,
  input  logic [H_W-1:0] cfg_hact_last,
  input  logic [F_W-1:0] cfg_frame_len,
  input  logic [F_W-1:0] cfg_vsync_span,
  input  logic [F_W-1:0] cfg_vact_first,
  input  logic [F_W-1:0] cfg_vact_last,
  input  logic [F_W-1:0] cfg_vskew,
  input  logic           cfg_hsync_low,
  input  logic           cfg_vsync_low,
  input  logic [C_W-1:0] cfg_border,
  input  logic           cfg_uf_recover,
  input  logic [C_W-1:0] cfg_uf_color,
  input  logic           src_valid,
  input  logic [C_W-1:0] src_pixel,
  output logic           pix_req,
  output logic           hsync,
  output logic           vsync,
  output logic           de,
  output logic [C_W-1:0] pix_out,
  output logic           scan_active,
  output logic           frame_evt
);
  logic           running, evt, frame_last;
  logic [H_W-1:0] hcnt, s_line_len, s_hsw, s_hfirst, s_hlast;
  logic [F_W-1:0] fcnt, s_frame_len, s_vspan, s_vfirst, s_vlast;
  logic           s_hlow, s_vlow, s_recover;
  logic [C_W-1:0] s_border, s_ufc;

  fst_shadow #(.H_W(H_W), .F_W(F_W), .C_W(C_W)) u_shadow (
    .clk(clk), .rst(rst), .frame_last(frame_last), .cfg_enable(cfg_enable),
    .cfg_line_len(cfg_line_len), .cfg_hsync_width(cfg_hsync_width),
    .cfg_hact_first(cfg_hact_first), .cfg_hact_last(cfg_hact_last),
    .cfg_frame_len(cfg_frame_len), .cfg_vsync_span(cfg_vsync_span),
    .cfg_vact_first(cfg_vact_first), .cfg_vact_last(cfg_vact_last),
    .cfg_vskew(cfg_vskew), .cfg_hsync_low(cfg_hsync_low),
    .cfg_vsync_low(cfg_vsync_low), .cfg_border(cfg_border),
    .cfg_uf_recover(cfg_uf_recover), .cfg_uf_color(cfg_uf_color),
    .running(running), .evt(evt),
    .sh_line_len(s_line_len), .sh_hsync_width(s_hsw),
    .sh_hact_first(s_hfirst), .sh_hact_last(s_hlast),
    .sh_frame_len(s_frame_len), .sh_vsync_span(s_vspan),
    .sh_vact_first(s_vfirst), .sh_vact_last(s_vlast),
    .sh_hsync_low(s_hlow), .sh_vsync_low(s_vlow), .sh_border(s_border),
    .sh_uf_recover(s_recover), .sh_uf_color(s_ufc)
  );

  fst_counters #(.H_W(H_W), .F_W(F_W)) u_cnt (
    .clk(clk), .rst(rst), .running(running), .line_len(s_line_len),
    .frame_len(s_frame_len), .hcnt(hcnt), .fcnt(fcnt), .frame_last(frame_last)
  );

  fst_output #(.H_W(H_W), .F_W(F_W), .C_W(C_W)) u_out (
    .clk(clk), .rst(rst), .running(running), .hcnt(hcnt), .fcnt(fcnt),
    .hsync_width(s_hsw), .hact_first(s_hfirst), .hact_last(s_hlast),
    .vsync_span(s_vspan), .vact_first(s_vfirst), .vact_last(s_vlast),
    .hsync_low(s_hlow), .vsync_low(s_vlow), .border(s_border),
    .uf_recover(s_recover), .uf_color(s_ufc), .src_valid(src_valid),
    .src_pixel(src_pixel), .pix_req(pix_req), .hsync(hsync), .vsync(vsync),
    .de(de), .pix_out(pix_out)
  );

  assign scan_active = running;
  assign frame_evt   = evt;

  // R10: the wrap pulse coincides with both counters back at the origin
  p_evt_at_origin_r10: assert property (@(posedge clk) disable iff (rst)
    frame_evt |-> (hcnt == '0 && fcnt == '0));

  // R2: nothing is requested while idle
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !scan_active |=> !de);

endmodule

// File: tb/sim_frame_scan_timer.sv
module sim_frame_scan_timer;
  localparam int CLK_PERIOD = 10;
  localparam int H_W = 12;
  localparam int F_W = 24;
  localparam int C_W = 24;
  localparam int WATCHDOG = 150000;

  // mode-style vectors: htotal, hdisplay, hsync_start, hsync_end,
  // vtotal, vdisplay, vsync_start, vsync_end, skew, polarity, recover, starve
  localparam int NV = 3;
  localparam int VEC [NV][12] = '{
    '{10, 5, 7, 9, 6, 3, 4, 5, 0, 0, 1, 0},
    '{10, 5, 7, 9, 6, 3, 4, 5, 3, 3, 1, 1},
    '{ 8, 4, 5, 7, 5, 2, 3, 4, 0, 1, 0, 1}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic           cfg_enable = 1'b0;
  logic [H_W-1:0] cfg_line_len = '0, cfg_hsync_width = '0, cfg_hact_first = '0, cfg_hact_last = '0;
  logic [F_W-1:0] cfg_frame_len = '0, cfg_vsync_span = '0, cfg_vact_first = '0, cfg_vact_last = '0, cfg_vskew = '0;
  logic           cfg_hsync_low = 1'b0, cfg_vsync_low = 1'b0, cfg_uf_recover = 1'b0;
  logic [C_W-1:0] cfg_border = '0, cfg_uf_color = '0;
  logic           src_valid = 1'b0;
  logic [C_W-1:0] src_pixel = '0;
  logic           pix_req, hsync, vsync, de, scan_active, frame_evt;
  logic [C_W-1:0] pix_out;

  int n_tests = 0, n_fail = 0, cycles = 0;
  int ht, hsw, h0, h1, per, vsl, v0, v1, sk, hp, vp, rec, starve;
  logic [C_W-1:0] bord, ufc;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_scan_timer #(.H_W(H_W), .F_W(F_W), .C_W(C_W)) u0 (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  function automatic logic in_win(int p);
    int h = p % ht;
    return (h >= h0) && (h <= h1) && (p >= v0 + sk) && (p <= v1 + sk);
  endfunction

  function automatic logic [C_W-1:0] pix_for(int p);
    return 24'hA50000 | C_W'(p & 16'hFFFF);
  endfunction

  function automatic logic valid_for(int p);
    return !(starve != 0 && (p % 5) == 3);
  endfunction

  task automatic drive_src(int p);
    src_valid = valid_for(p);
    src_pixel = pix_for(p);
  endtask

  task automatic run_frame(input int idx, input bit glitch);
    int vt = VEC[idx][4];
    logic [C_W-1:0] ex;
    ht = VEC[idx][0];
    hsw = VEC[idx][3] - VEC[idx][2];
    h0 = ht - VEC[idx][2];
    h1 = ht - (VEC[idx][2] - VEC[idx][1]) - 1;
    per = vt * ht;
    vsl = (VEC[idx][7] - VEC[idx][6]) * ht;
    v0 = (vt - VEC[idx][6]) * ht;
    v1 = per - (VEC[idx][6] - VEC[idx][5]) * ht - 1;
    sk = VEC[idx][8];
    hp = VEC[idx][9] & 1;
    vp = (VEC[idx][9] >> 1) & 1;
    rec = VEC[idx][10];
    starve = VEC[idx][11];
    bord = 24'h102030 + C_W'(idx * 24'h010101);
    ufc = 24'h0000FF + C_W'(idx << 8);
    cfg_line_len = H_W'(ht); cfg_hsync_width = H_W'(hsw);
    cfg_hact_first = H_W'(h0); cfg_hact_last = H_W'(h1);
    cfg_frame_len = F_W'(per); cfg_vsync_span = F_W'(vsl);
    cfg_vact_first = F_W'(v0); cfg_vact_last = F_W'(v1); cfg_vskew = F_W'(sk);
    cfg_hsync_low = hp[0]; cfg_vsync_low = vp[0];
    cfg_border = bord; cfg_uf_recover = rec[0]; cfg_uf_color = ufc;
    cfg_enable = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(scan_active == 1'b1, "R2", scan_active, 1);
    chk(pix_req == in_win(0), "R6", pix_req, in_win(0));
    drive_src(0);
    for (int p = 0; p < per; p++) begin
      @(posedge clk); @(negedge clk);
      chk(hsync == (((p % ht) < hsw) ^ hp[0]), "R3 R9", hsync, ((p % ht) < hsw) ^ hp[0]);
      chk(vsync == ((p < vsl) ^ vp[0]), "R4 R9", vsync, (p < vsl) ^ vp[0]);
      chk(de == in_win(p), "R5", de, in_win(p));
      if (!in_win(p)) begin
        chk(pix_out == bord, "R7", pix_out, bord);
      end else if (valid_for(p)) begin
        chk(pix_out == pix_for(p), "R6", pix_out, pix_for(p));
      end else begin
        ex = (rec != 0) ? ufc : '0;
        chk(pix_out == ex, "R8", pix_out, ex);
      end
      chk(scan_active == (p != per - 1), "R10", scan_active, p != per - 1);
      chk(frame_evt == (p == per - 1), "R10", frame_evt, p == per - 1);
      if (p == 1) cfg_enable = 1'b0;
      if (glitch && p == per / 2) begin
        // R11: mid-frame edits must leave the rest of this frame untouched
        cfg_hsync_width = H_W'(1);
        cfg_hsync_low = ~hp[0];
        cfg_vsync_low = ~vp[0];
        cfg_border = 24'h0F0F0F;
      end
      if (p < per - 1) begin
        chk(pix_req == in_win(p + 1), "R6", pix_req, in_win(p + 1));
        drive_src(p + 1);
      end
    end
    @(posedge clk); @(negedge clk);
    chk(scan_active == 1'b0 && de == 1'b0 && pix_req == 1'b0, "R10", scan_active, 0);
    chk(hsync == cfg_hsync_low, glitch ? "R11" : "R9", hsync, cfg_hsync_low);
    chk(vsync == cfg_vsync_low, glitch ? "R11" : "R9", vsync, cfg_vsync_low);
    chk(pix_out == cfg_border, glitch ? "R11" : "R7", pix_out, cfg_border);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(hsync == 0 && vsync == 0 && de == 0, "R1", {hsync, vsync, de}, 0);
    chk(pix_req == 0 && scan_active == 0 && frame_evt == 0, "R1", {pix_req, scan_active, frame_evt}, 0);
    chk(pix_out == '0, "R1", pix_out, 0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(scan_active == 1'b0 && de == 1'b0, "R2", scan_active, 0);
    for (int i = 0; i < NV; i++) run_frame(i, 1'b0);
    run_frame(0, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(scan_active == 1'b0, "R2", scan_active, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule